// File: doc/BRIEF.md
# Write Address Posting Gate

This block takes write burst requests from an upstream command source and places them on an AXI4 write address channel. Each request carries a start address, a burst length in AWLEN encoding (beats minus one) and a byte count. Accepted requests wait in a small first-in first-out queue. A single staging register sits behind the queue. When a request moves from the queue into the staging register, the block pulses a load strobe and shows the burst length. External logic therefore learns the size of the next burst before its address reaches the bus.

An external permission input decides when the staged request may be offered on the address channel. While permission is low, or while the halt input is high, no new address is raised. The block also watches the write data channel. It pulses a completion strobe for every beat that completes a handshake with WLAST set. It keeps a running balance of addresses issued against bursts completed, and it reports halt-complete when nothing is queued, staged or outstanding. A request whose byte count is zero is discarded and raises a sticky error flag.

All registers use a synchronous active-low reset.

Top module: `wap_top`

## Requirements
- R1: The queue holds DEPTH (default 4) requests and the staging register holds one more. `req_ready` is 1 whenever the queue is not full and 0 when it is full. With permission held at 0, exactly 5 requests are accepted before `req_ready` falls.
- R2: A request accepted with `req_bytes` equal to 0 is dropped: it never produces a load strobe or an address. `err` reads 1 from the cycle after that handshake and stays 1 until `rst_n` is driven low.
- R3: `len_load` is high for one cycle each time a request moves from the queue into the staging register. In that cycle `len_value` equals that request's length. `awvalid` is 0 in that cycle, so the strobe always comes before the matching address.
- R4: `awvalid` rises only in the cycle after a clock edge at which `post_allow` was 1 and `halt` was 0. Once raised, it stays high until `awready` is sampled high, even if permission drops.
- R5: While `awvalid` is 1 and `awready` is 0, `awaddr` and `awlen` hold their values into the next cycle.
- R6: `posted` is high for exactly one cycle, the cycle after each clock edge at which `awvalid` and `awready` were both 1.
- R7: `burst_done` is high for exactly one cycle, the cycle after each edge at which `wvalid`, `wready` and `wlast` were all 1. Beats without `wlast`, and beats without `wready`, produce no pulse.
- R8: `halt_done` is 1 one cycle after an edge at which all of the following held: `halt` was 1, the queue was empty, the staging register was empty, and the number of address handshakes equalled the number of completed WLAST beats. Otherwise `halt_done` is 0.
- R9: `rst_n` must be held low for at least three cycles. After reset, `err`, `len_load`, `posted`, `burst_done`, `halt_done` and `awvalid` are 0, and `req_ready` is 1.
- R10: Addresses appear on the write address channel in the same order in which their requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Burst start address |
| req_len | input | LEN_W | Burst length, beats minus one |
| req_bytes | input | BYTES_W | Byte count; zero is an error |
| post_allow | input | 1 | 1 permits raising a new address |
| halt | input | 1 | Stop issuing new addresses |
| halt_done | output | 1 | Halted with nothing queued or outstanding |
| err | output | 1 | Sticky zero-byte-count error |
| len_load | output | 1 | One-cycle strobe when a request leaves the queue |
| len_value | output | LEN_W | Length of the request just dequeued |
| posted | output | 1 | One-cycle strobe after each address handshake |
| burst_done | output | 1 | One-cycle strobe after each WLAST handshake |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Write address |
| awlen | output | LEN_W | Write burst length |
| wvalid | input | 1 | Write data valid (observed only) |
| wready | input | 1 | Write data ready (observed only) |
| wlast | input | 1 | Last beat of a write burst (observed only) |

## Verification
If the queue pointers or occupancy count go wrong, the failure shows at the ports within a few cycles. Either `req_ready` falls at the wrong fill level, or an address appears out of order or repeats in the next handshakes on the address channel. A staging state machine that leaves its waiting state without permission raises `awvalid` on the very next cycle. One that moves its registers while stalled changes `awaddr` during a held offer. A wrong issued-versus-completed balance does not show until halt is requested: `halt_done` then either never rises or rises while a burst is still open. The halt scenario is therefore run with one burst deliberately left outstanding.

// File: rtl/wap_pkg.sv
package wap_pkg;

  // staging register state
  typedef enum logic [1:0] {
    STG_EMPTY = 2'd0,  // nothing staged
    STG_HELD  = 2'd1,  // staged, waiting for permission
    STG_OFFER = 2'd2   // awvalid raised
  } stg_state_t;

endpackage

// File: rtl/wap_queue.sv
module wap_queue #(
  parameter int WIDTH = 40,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign full    = (cnt == FULL_CNT);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);

  // R1
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

endmodule

// File: rtl/wap_issue.sv
module wap_issue
  import wap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [LEN_W-1:0]  q_len,
  output logic              q_pop,
  input  logic              post_allow,
  input  logic              halt,
  output logic              len_load,
  output logic [LEN_W-1:0]  len_value,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [LEN_W-1:0]  awlen,
  output logic              posted,
  output logic              aw_fire,
  output logic              stage_busy
);
  stg_state_t        state, state_nx;
  logic [ADDR_W-1:0] stg_addr;
  logic [LEN_W-1:0]  stg_len;
  logic              may_raise;

  assign awvalid    = (state == STG_OFFER);
  assign awaddr     = stg_addr;
  assign awlen      = stg_len;
  assign aw_fire    = awvalid && awready;
  assign stage_busy = (state != STG_EMPTY);
  assign may_raise  = post_allow && !halt;

  // pull from the queue when the stage is free or frees this cycle
  assign q_pop = !q_empty && ((state == STG_EMPTY) || aw_fire);

  always_comb begin
    state_nx = state;
    case (state)
      STG_EMPTY: if (q_pop)     state_nx = STG_HELD;
      STG_HELD:  if (may_raise) state_nx = STG_OFFER;
      STG_OFFER: if (awready)   state_nx = q_pop ? STG_HELD : STG_EMPTY;
      default:                  state_nx = STG_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= STG_EMPTY;
      stg_addr  <= '0;
      stg_len   <= '0;
      len_load  <= 1'b0;
      len_value <= '0;
      posted    <= 1'b0;
    end else begin
      state    <= state_nx;
      len_load <= q_pop;
      posted   <= aw_fire;
      if (q_pop) begin
        stg_addr  <= q_addr;
        stg_len   <= q_len;
        len_value <= q_len;
      end
    end
  end

  // R4
  aw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!awvalid ##1 awvalid) |-> $past(post_allow && !halt));

  // R4
  aw_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> awvalid);

  // R5
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> ($stable(awaddr) && $stable(awlen)));

  // R3
  len_before_aw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_load |-> !awvalid);

  // R6
  posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    posted |-> $past(awvalid && awready));

endmodule

// File: rtl/wap_track.sv
module wap_track #(
  parameter int OUT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aw_fire,
  input  logic wvalid,
  input  logic wready,
  input  logic wlast,
  input  logic halt,
  input  logic idle,
  output logic burst_done,
  output logic halt_done
);
  // issued minus completed, two's complement so data ahead of address is fine
  logic [OUT_W-1:0] balance;
  logic             w_end;

  assign w_end = wvalid && wready && wlast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      balance    <= '0;
      burst_done <= 1'b0;
      halt_done  <= 1'b0;
    end else begin
      burst_done <= w_end;
      halt_done  <= halt && idle && (balance == '0);
      case ({aw_fire, w_end})
        2'b10:   balance <= balance + 1'b1;
        2'b01:   balance <= balance - 1'b1;
        default: balance <= balance;
      endcase
    end
  end

  // R7
  burst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(wvalid && wready && wlast));

  // R8
  halt_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done |-> $past(halt && idle));

endmodule

// File: rtl/wap_top.sv
module wap_top #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 8,
  parameter int BYTES_W = 23,
  parameter int DEPTH   = 4,
  parameter int OUT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [BYTES_W-1:0] req_bytes,
  input  logic               post_allow,
  input  logic               halt,
  output logic               halt_done,
  output logic               err,
  output logic               len_load,
  output logic [LEN_W-1:0]   len_value,
  output logic               posted,
  output logic               burst_done,
  output logic               awvalid,
  input  logic               awready,
  output logic [ADDR_W-1:0]  awaddr,
  output logic [LEN_W-1:0]   awlen,
  input  logic               wvalid,
  input  logic               wready,
  input  logic               wlast
);
  localparam int ENT_W = ADDR_W + LEN_W;

  logic             q_full, q_empty, q_pop, q_push;
  logic [ENT_W-1:0] q_head;
  logic             req_fire, zero_req;
  logic             aw_fire, stage_busy;

  assign req_ready = !q_full;
  assign req_fire  = req_valid && req_ready;
  assign zero_req  = (req_bytes == '0);
  assign q_push    = req_fire && !zero_req;

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else if (req_fire && zero_req) err <= 1'b1;
  end

  wap_queue #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data ({req_addr, req_len}),
    .pop       (q_pop),
    .head_data (q_head),
    .full      (q_full),
    .empty     (q_empty)
  );

  wap_issue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_empty    (q_empty),
    .q_addr     (q_head[ENT_W-1:LEN_W]),
    .q_len      (q_head[LEN_W-1:0]),
    .q_pop      (q_pop),
    .post_allow (post_allow),
    .halt       (halt),
    .len_load   (len_load),
    .len_value  (len_value),
    .awvalid    (awvalid),
    .awready    (awready),
    .awaddr     (awaddr),
    .awlen      (awlen),
    .posted     (posted),
    .aw_fire    (aw_fire),
    .stage_busy (stage_busy)
  );

  wap_track #(.OUT_W(OUT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .aw_fire    (aw_fire),
    .wvalid     (wvalid),
    .wready     (wready),
    .wlast      (wlast),
    .halt       (halt),
    .idle       (q_empty && !stage_busy),
    .burst_done (burst_done),
    .halt_done  (halt_done)
  );

  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R2
  zero_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && zero_req) |=> err);

endmodule

// File: tb/sim_wap_top.sv
module sim_wap_top;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam int BW = 23;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          req_valid = 0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [BW-1:0] req_bytes = '0;
  logic          post_allow = 0, halt = 0;
  logic          halt_done, err, len_load, posted, burst_done, awvalid;
  logic [LW-1:0] len_value, awlen;
  logic [AW-1:0] awaddr;
  logic          awready = 0, wvalid = 0, wready = 0, wlast = 0;

  int tests = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  wap_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_bytes(req_bytes),
    .post_allow(post_allow), .halt(halt), .halt_done(halt_done), .err(err),
    .len_load(len_load), .len_value(len_value), .posted(posted),
    .burst_done(burst_done), .awvalid(awvalid), .awready(awready),
    .awaddr(awaddr), .awlen(awlen), .wvalid(wvalid), .wready(wready),
    .wlast(wlast)
  );

  // monitor, sampled on the falling edge
  int            len_n = 0, hs_n = 0, post_n = 0, bd_n = 0, wl_n = 0;
  logic [LW-1:0] len_log [0:31];
  logic [AW-1:0] hs_addr [0:31];
  logic [LW-1:0] hs_len  [0:31];
  logic          p_len = 0, p_post = 0, p_bd = 0, p_aw = 0, p_hs = 0, p_wl = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (len_load) begin
        if (len_n < 32) len_log[len_n] = len_value;
        len_n++;
        // R3 strobe comes before its address
        check(!awvalid, "R3", "awvalid during len_load", awvalid, 0);
        check(!p_len, "R3", "len_load wider than one cycle", 1, 0);
      end
      if (posted) begin
        post_n++;
        // R6 one cycle after handshake
        check(p_hs && !p_post, "R6", "posted timing", p_hs, 1);
      end
      if (burst_done) begin
        bd_n++;
        // R7 one cycle after WLAST beat
        check(p_wl && !p_bd, "R7", "burst_done timing", p_wl, 1);
      end
      if (awvalid && awready) begin
        if (hs_n < 32) begin
          hs_addr[hs_n] = awaddr;
          hs_len[hs_n]  = awlen;
        end
        hs_n++;
      end
      if (wvalid && wready && wlast) wl_n++;
      p_len  = len_load;
      p_post = posted;
      p_bd   = burst_done;
      p_aw   = awvalid;
      p_hs   = awvalid && awready;
      p_wl   = wvalid && wready && wlast;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_req(input logic [AW-1:0] a, input logic [LW-1:0] l,
                          input logic [BW-1:0] b);
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_len = l; req_bytes = b;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic send_beat(input logic last, input logic rdy);
    @(posedge clk); #1;
    wvalid = 1; wready = rdy; wlast = last;
    @(posedge clk); #1;
    wvalid = 0; wready = 0; wlast = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0;
    cycles(3);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(err == 0, "R9", "err after reset", err, 0);
    check(len_load == 0 && posted == 0 && burst_done == 0, "R9",
          "strobes after reset", {len_load, posted, burst_done}, 0);
    check(awvalid == 0 && halt_done == 0, "R9", "awvalid/halt_done after reset",
          {awvalid, halt_done}, 0);
    check(req_ready == 1, "R9", "req_ready after reset", req_ready, 1);
  endtask

  task automatic t_permission();
    int l0, h0;
    bit rose;
    l0 = len_n; h0 = hs_n; rose = 0;
    post_allow = 0; awready = 1;
    push_req(32'h0000_1000, 8'd15, 23'd256);
    repeat (8) begin
      @(negedge clk);
      if (awvalid) rose = 1;
    end
    // R4 no address while permission is 0
    check(!rose, "R4", "awvalid with post_allow=0", rose, 0);
    // R3 length reported on dequeue
    check(len_n == l0 + 1, "R3", "len_load count", len_n - l0, 1);
    check(len_log[l0] == 8'd15, "R3", "len_value", len_log[l0], 15);
    @(posedge clk); #1;
    post_allow = 1;
    cycles(5);
    check(hs_n == h0 + 1, "R4", "issued after permission", hs_n - h0, 1);
    check(hs_addr[h0] == 32'h0000_1000 && hs_len[h0] == 8'd15, "R4",
          "issued address", hs_addr[h0], 32'h1000);
    check(post_n == h0 + 1, "R6", "posted count", post_n, h0 + 1);
  endtask

  task automatic t_hold();
    logic [AW-1:0] a0;
    logic [LW-1:0] l0;
    int h0;
    h0 = hs_n;
    post_allow = 1; awready = 0;
    push_req(32'h0000_2040, 8'd3, 23'd64);
    cycles(4);
    @(negedge clk);
    check(awvalid == 1, "R4", "offer raised", awvalid, 1);
    a0 = awaddr; l0 = awlen;
    @(posedge clk); #1;
    post_allow = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      // R5 fields stable, R4 valid persists without permission
      check(awvalid && awaddr == a0 && awlen == l0, "R5", "held offer stable",
            awaddr, a0);
    end
    @(posedge clk); #1;
    awready = 1;
    cycles(3);
    check(hs_n == h0 + 1 && hs_addr[h0] == 32'h0000_2040, "R5",
          "held offer accepted", hs_addr[h0], 32'h2040);
  endtask

  task automatic t_fill_order();
    int acc, h0;
    acc = 0; h0 = hs_n;
    post_allow = 0; awready = 1;
    cycles(2);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      req_valid = 1; req_addr = 32'h0001_0000 + AW'(i * 16);
      req_len = LW'(i + 1); req_bytes = 23'd32;
      @(negedge clk);
      if (!req_ready) break;
      acc++;
    end
    @(posedge clk); #1;
    req_valid = 0;
    // R1 four queued plus one staged
    check(acc == 5, "R1", "requests accepted before full", acc, 5);
    @(negedge clk);
    check(req_ready == 0, "R1", "req_ready when full", req_ready, 0);
    @(posedge clk); #1;
    post_allow = 1;
    cycles(30);
    check(hs_n == h0 + 5, "R10", "drained count", hs_n - h0, 5);
    for (int i = 0; i < 5; i++)
      check(hs_addr[h0 + i] == 32'h0001_0000 + AW'(i * 16), "R10",
            "address order", hs_addr[h0 + i], 32'h0001_0000 + i * 16);
    check(req_ready == 1, "R1", "req_ready after drain", req_ready, 1);
  endtask

  task automatic t_zero();
    int l0, h0;
    l0 = len_n; h0 = hs_n;
    post_allow = 1; awready = 1;
    check(err == 0, "R2", "err before zero request", err, 0);
    push_req(32'h0000_3000, 8'd7, 23'd0);
    @(negedge clk);
    check(err == 1, "R2", "err after zero request", err, 1);
    cycles(6);
    check(len_n == l0 && hs_n == h0, "R2", "zero request dropped",
          hs_n - h0, 0);
    push_req(32'h0000_3100, 8'd1, 23'd8);
    cycles(6);
    check(err == 1, "R2", "err sticky", err, 1);
    check(hs_n == h0 + 1, "R2", "later request still issued", hs_n - h0, 1);
  endtask

  task automatic t_wdata();
    int b0, n;
    b0 = bd_n;
    n = hs_n - wl_n;
    send_beat(0, 1);
    send_beat(1, 0);
    for (int i = 0; i < n; i++) send_beat(1, 1);
    cycles(2);
    // R7 only beats with ready and last count
    check(bd_n == b0 + n, "R7", "burst_done count", bd_n - b0, n);
  endtask

  task automatic t_halt();
    int h0;
    bit rose;
    h0 = hs_n; rose = 0;
    post_allow = 1; awready = 1;
    @(posedge clk); #1;
    halt = 1;
    cycles(3);
    @(negedge clk);
    check(halt_done == 1, "R8", "halt_done when idle and balanced", halt_done, 1);
    push_req(32'h0000_4000, 8'd2, 23'd12);
    repeat (6) begin
      @(negedge clk);
      if (awvalid) rose = 1;
    end
    check(!rose, "R4", "awvalid while halted", rose, 0);
    check(halt_done == 0, "R8", "halt_done with staged request", halt_done, 1'b0);
    @(posedge clk); #1;
    halt = 0;
    cycles(4);
    check(hs_n == h0 + 1, "R8", "issued after halt released", hs_n - h0, 1);
    @(posedge clk); #1;
    halt = 1;
    cycles(3);
    @(negedge clk);
    check(halt_done == 0, "R8", "halt_done with open burst", halt_done, 0);
    send_beat(1, 1);
    cycles(2);
    @(negedge clk);
    check(halt_done == 1, "R8", "halt_done after WLAST", halt_done, 1);
    @(posedge clk); #1;
    halt = 0;
    @(negedge clk); @(negedge clk);
    check(halt_done == 0, "R8", "halt_done follows halt", halt_done, 0);
  endtask

  task automatic t_rereset();
    do_reset();
    check(err == 0, "R2", "err cleared by reset", err, 0);
    t_reset();
  endtask

  initial begin
    cycles(4);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_permission();
    t_hold();
    t_fill_order();
    t_zero();
    t_wdata();
    t_halt();
    t_rereset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule